// File: doc/BRIEF.md
# Register String Load/Store Sequencer

This block moves a run of bytes between memory and a 32-entry register file of 32-bit registers. A command names a starting register, a starting byte address, a byte count and a direction. In string mode the sequencer transfers as many whole 32-bit words as the count allows, one register per word. It then transfers the last one to three bytes one at a time. On a load these bytes are packed into the next register from its most significant byte downward. On a store they are taken from that register in the same order. The register index wraps from 31 back to 0. In multiple-word mode the count is ignored and whole words are moved for every register from the starting one up to register 31.

The sequencer drives a memory request port with a word/byte size select and a ready handshake. It also drives a register-file port with an asynchronous read and a synchronous write. It holds one command at a time. The register storage and the memory are outside the block.

Top module: `rstr_seq`

## Requirements
- R1: After reset, busy, done, mem_req and rf_we are all 0.
- R2: In string mode, while more than 3 bytes remain, each access is a word access (mem_byte=0). After each accepted word the address advances by 4, the count drops by 4 and the register index advances by 1.
- R3: In string mode the remaining 1 to 3 bytes are sent as byte accesses (mem_byte=1), and the address advances by 1 per byte.
- R4: On a load tail, the byte read on mem_rdata[7:0] for the first, second and third remaining byte lands in register bits 31:24, 23:16 and 15:8 in that order. All register bits the tail does not cover are written as zero.
- R5: On a store tail, the first, second and third remaining byte come from register bits 31:24, 23:16 and 15:8 in that order. Each is presented on mem_wdata[7:0] with mem_wdata[31:8] zero.
- R6: A transfer that goes past register 31 continues at register 0.
- R7: In multiple-word mode (cmd_multi=1) the block moves one word for each register from cmd_reg through 31, the address advancing by 4 each time. cmd_count is ignored.
- R8: A string command with a byte count of zero makes no memory access and raises done in the cycle after it is accepted.
- R9: While mem_req is high and mem_ready is low, mem_addr, mem_we, mem_byte and mem_wdata hold their values and the request stays up.
- R10: done is high for one cycle, in the cycle right after the handshake of the final access, and busy is low in that cycle.
- R11: cmd_valid is ignored while busy is high, and the running transfer completes unchanged.
- R12: A word load writes the whole of mem_rdata into the current register. A word store presents the current register on mem_wdata. The register file is written only in a cycle that has a completed handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_store | input | 1 | 1 = register to memory, 0 = memory to register |
| cmd_multi | input | 1 | 1 = multiple-word mode, 0 = string mode |
| cmd_reg | input | 5 | Starting register index |
| cmd_addr | input | 32 | Starting byte address |
| cmd_count | input | 8 | Byte count (string mode) |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_byte | output | 1 | 1 = byte access, 0 = word access |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data (a byte access uses bits 7:0) |
| mem_rdata | input | 32 | Read data (a byte access uses bits 7:0) |
| mem_ready | input | 1 | Memory accepts or completes the request this cycle |
| rf_raddr | output | 5 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |

## Verification
Loads and stores are tried with counts that are whole words only, bytes only, and words followed by one, two or three tail bytes. These separate errors in the phase split from errors in the byte-lane packing. Starting registers of 30 and 31 show whether the index wraps to 0 or runs off the end. Multiple-word runs with a nonzero count show that the count is ignored in that mode. Running each pattern with both an always-ready memory and a stalling memory exposes requests that move before they are accepted, and a done that is misplaced relative to the last handshake.

// File: rtl/rstr_pkg.sv
// Shared constants and types for the register string sequencer.
// Assumes a 32-bit word made of four 8-bit bytes, packed big-endian.
package rstr_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } rstr_state_e;
endpackage

// File: rtl/rstr_ctrl.sv
// Sequencer control: accepts a command when idle, walks the address, the
// register index and the remaining count, and picks a word or byte access.
// Assumes the memory completes a request in the cycle mem_ready is high.
module rstr_ctrl
    import rstr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic              cmd_multi,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REG_W-1:0]  cur_reg,
    output logic [LANE_W-1:0] lane,
    output logic              last_acc,
    output logic              start
);
    localparam logic [REG_W-1:0] REG_TOP = REG_W'((1 << REG_W) - 1);
    localparam logic [CNT_W-1:0] WORD_BYTES = CNT_W'(LANES);

    rstr_state_e       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [REG_W-1:0]  reg_q;
    logic [CNT_W-1:0]  rem_q;
    logic [LANE_W-1:0] lane_q;
    logic              multi_q;
    logic              store_q;
    logic              done_q;
    logic              is_word;
    logic              zero_cmd;
    logic              hs;

    // Decode the current access type and whether it is the final one.
    always_comb begin
        is_word  = multi_q | (rem_q >= WORD_BYTES);
        if (multi_q)
            last_acc = (reg_q == REG_TOP);
        else if (is_word)
            last_acc = (rem_q == WORD_BYTES);
        else
            last_acc = (rem_q == CNT_W'(1));
        start    = (state_q == ST_IDLE) & cmd_valid;
        zero_cmd = ~cmd_multi & (cmd_count == '0);
        hs       = (state_q == ST_XFER) & mem_ready;
    end

    // Advance the transfer state on each accepted access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            reg_q   <= '0;
            rem_q   <= '0;
            lane_q  <= '0;
            multi_q <= 1'b0;
            store_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                addr_q  <= cmd_addr;
                reg_q   <= cmd_reg;
                rem_q   <= cmd_count;
                lane_q  <= '0;
                multi_q <= cmd_multi;
                store_q <= cmd_store;
                if (zero_cmd)
                    done_q <= 1'b1;
                else
                    state_q <= ST_XFER;
            end else if (hs) begin
                if (is_word) begin
                    addr_q <= addr_q + ADDR_W'(LANES);
                    reg_q  <= reg_q + REG_W'(1);
                    if (!multi_q)
                        rem_q <= rem_q - WORD_BYTES;
                end else begin
                    addr_q <= addr_q + ADDR_W'(1);
                    rem_q  <= rem_q - CNT_W'(1);
                    lane_q <= lane_q + LANE_W'(1);
                end
                if (last_acc) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy     = (state_q == ST_XFER);
    assign done     = done_q;
    assign mem_req  = busy;
    assign mem_we   = busy & store_q;
    assign mem_byte = busy & ~is_word;
    assign mem_addr = addr_q;
    assign cur_reg  = reg_q;
    assign lane     = lane_q;

    // R9: a stalled request holds its attributes
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_byte)));

    // R2: word accesses step the address by a word
    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_byte && !last_acc)
            |=> (mem_addr == $past(mem_addr) + ADDR_W'(LANES)));

    // R3: byte accesses step the address by one
    p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_byte && !last_acc)
            |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // R6: the register index wraps past the top register
    p_reg_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_byte && !last_acc && cur_reg == REG_TOP)
            |=> (cur_reg == '0));

    // R10: done follows the final handshake and only when idle
    p_done_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && last_acc) |=> (done && !busy));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/rstr_lane.sv
// Byte-lane datapath: packs tail bytes of a load from the top byte down with
// zero fill, and picks the matching tail byte of a store. Assumes the lane
// index counts 0,1,2 over the tail bytes of one transfer.
module rstr_lane
    import rstr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              byte_ld_hs,
    input  logic              tail,
    input  logic              store,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] load_word
);
    localparam int SH_W = $clog2(WORD_W);

    logic [WORD_W-1:0] acc_q;
    logic [SH_W-1:0]   byte_sh;
    logic [WORD_W-1:0] placed_in;
    logic [BYTE_W-1:0] st_byte;

    // Bit offset of the current tail lane: top byte first.
    always_comb begin
        byte_sh   = SH_W'(WORD_W - BYTE_W) - SH_W'({lane, 3'b000});
        placed_in = {{(WORD_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]} << byte_sh;
        st_byte   = BYTE_W'(rf_rdata >> byte_sh);
        load_word = tail ? (acc_q | placed_in) : mem_rdata;
        if (!store)
            mem_wdata = '0;
        else if (tail)
            mem_wdata = {{(WORD_W-BYTE_W){1'b0}}, st_byte};
        else
            mem_wdata = rf_rdata;
    end

    // Collect tail bytes of a load until the last one is written.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clr)
            acc_q <= '0;
        else if (byte_ld_hs)
            acc_q <= acc_q | placed_in;
    end

    // R4: a packed tail never reaches the lowest byte of the register
    p_tail_low_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tail && !store) |-> (load_word[BYTE_W-1:0] == '0));

    // R5: a store tail drives only the low byte lane
    p_store_tail_narrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tail && store) |-> (mem_wdata[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/rstr_seq.sv
// Top of the register string sequencer: joins the control walk with the
// byte-lane datapath and drives the register-file port. Assumes the register
// file reads combinationally and writes on the clock edge.
module rstr_seq
    import rstr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic              cmd_multi,
    input  logic [REG_W-1:0]  cmd_reg,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [REG_W-1:0]  rf_raddr,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata
);
    logic [REG_W-1:0]  cur_reg;
    logic [LANE_W-1:0] lane;
    logic              last_acc;
    logic              start;
    logic              hs_load;

    rstr_ctrl #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .REG_W  (REG_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_store (cmd_store),
        .cmd_multi (cmd_multi),
        .cmd_reg   (cmd_reg),
        .cmd_addr  (cmd_addr),
        .cmd_count (cmd_count),
        .mem_ready (mem_ready),
        .busy      (busy),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_byte  (mem_byte),
        .mem_addr  (mem_addr),
        .cur_reg   (cur_reg),
        .lane      (lane),
        .last_acc  (last_acc),
        .start     (start)
    );

    // A completed handshake of a load access.
    assign hs_load = mem_req & mem_ready & ~mem_we;

    rstr_lane u_lane (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start),
        .byte_ld_hs (hs_load & mem_byte),
        .tail       (mem_byte),
        .store      (mem_we),
        .lane       (lane),
        .mem_rdata  (mem_rdata),
        .rf_rdata   (rf_rdata),
        .mem_wdata  (mem_wdata),
        .load_word  (rf_wdata)
    );

    // Register-file port: read and write the current register.
    always_comb begin
        rf_raddr = cur_reg;
        rf_waddr = cur_reg;
        rf_we    = hs_load & (~mem_byte | last_acc);
    end

    // R12: register writes only happen on a completed load handshake
    p_rf_we_hs_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    // R11: no request while the block reports idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we));
endmodule

// File: tb/tb_rstr_seq.sv
`timescale 1ns/1ps
module tb_rstr_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_store = 1'b0;
    logic        cmd_multi = 1'b0;
    logic [4:0]  cmd_reg = '0;
    logic [31:0] cmd_addr = '0;
    logic [7:0]  cmd_count = '0;
    logic        busy, done, mem_req, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;

    always #4 clk = ~clk;

    rstr_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_multi(cmd_multi), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr),
        .cmd_count(cmd_count), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    // Bench-side memory (big-endian bytes) and register file.
    logic [7:0]  bmem [256];
    logic [31:0] brf  [32];
    logic [7:0]  emem [256];
    logic [31:0] erf  [32];

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_hs = 0;
    int word_hs = 0;
    int byte_hs = 0;
    int hold_err = 0;
    int exp_words = 0;
    int exp_bytes = 0;
    bit stall_en = 1'b0;
    logic [7:0] lfsr = 8'h5b;

    // Combinational read ports of the bench models.
    always_comb begin
        logic [7:0] a;
        a = mem_addr[7:0];
        if (mem_byte)
            mem_rdata = {24'h0, bmem[a]};
        else
            mem_rdata = {bmem[a], bmem[8'(a+1)], bmem[8'(a+2)], bmem[8'(a+3)]};
        rf_rdata = brf[rf_raddr];
    end

    // Apply writes and count handshakes on each rising edge.
    always @(posedge clk) begin
        logic [7:0] a;
        a = mem_addr[7:0];
        cyc = cyc + 1;
        if (mem_req && mem_ready) begin
            last_hs = cyc - 1;
            if (mem_byte) byte_hs = byte_hs + 1;
            else          word_hs = word_hs + 1;
            if (mem_we) begin
                if (mem_byte) bmem[a] = mem_wdata[7:0];
                else begin
                    bmem[a]         = mem_wdata[31:24];
                    bmem[8'(a + 1)] = mem_wdata[23:16];
                    bmem[8'(a + 2)] = mem_wdata[15:8];
                    bmem[8'(a + 3)] = mem_wdata[7:0];
                end
            end
        end
        if (rf_we) brf[rf_waddr] = rf_wdata;
    end

    // Stall generator and request-hold monitor, away from the active edge.
    logic        p_stall = 1'b0;
    logic [31:0] p_addr, p_wd;
    logic        p_we, p_byte;
    always @(negedge clk) begin
        if (p_stall && (mem_req !== 1'b1 || mem_addr !== p_addr || mem_we !== p_we
                        || mem_byte !== p_byte || mem_wdata !== p_wd))
            hold_err = hold_err + 1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = stall_en ? (lfsr[0] & lfsr[2]) : 1'b1;
        p_stall = mem_req && !mem_ready;
        p_addr = mem_addr; p_wd = mem_wdata; p_we = mem_we; p_byte = mem_byte;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic init_state(input int v);
        for (int i = 0; i < 256; i++) bmem[i] = 8'(i * 13 + v * 5 + 1);
        for (int i = 0; i < 32; i++) brf[i] = {8'(i + 8'h40), 8'(i ^ v), 8'hA5, 8'(i + v + 1)};
    endtask

    // Expected outcome from the requirements, on a copy of the bench state.
    task automatic compute_ref(input bit st, input bit mu, input int r0,
                               input int a0, input int n0);
        int r, a, n, sh;
        logic [31:0] t;
        for (int i = 0; i < 256; i++) emem[i] = bmem[i];
        for (int i = 0; i < 32; i++) erf[i] = brf[i];
        r = r0; a = a0; n = n0;
        exp_words = 0; exp_bytes = 0;
        if (mu) begin
            for (int k = r0; k < 32; k++) begin
                if (st) begin
                    emem[(a) % 256]   = erf[k][31:24];
                    emem[(a+1) % 256] = erf[k][23:16];
                    emem[(a+2) % 256] = erf[k][15:8];
                    emem[(a+3) % 256] = erf[k][7:0];
                end else
                    erf[k] = {emem[a % 256], emem[(a+1) % 256], emem[(a+2) % 256], emem[(a+3) % 256]};
                a = a + 4; exp_words++;
            end
        end else begin
            while (n > 3) begin
                if (st) begin
                    emem[(a) % 256]   = erf[r][31:24];
                    emem[(a+1) % 256] = erf[r][23:16];
                    emem[(a+2) % 256] = erf[r][15:8];
                    emem[(a+3) % 256] = erf[r][7:0];
                end else
                    erf[r] = {emem[a % 256], emem[(a+1) % 256], emem[(a+2) % 256], emem[(a+3) % 256]};
                a = a + 4; n = n - 4; r = (r + 1) % 32; exp_words++;
            end
            t = '0; sh = 24;
            if (n > 0) begin
                while (n > 0) begin
                    if (st) emem[a % 256] = 8'(erf[r] >> sh);
                    else    t = t | (32'(emem[a % 256]) << sh);
                    a = a + 1; n = n - 1; sh = sh - 8; exp_bytes++;
                end
                if (!st) erf[r] = t;
            end
        end
    endtask

    task automatic compare_all(input string rtag, input string mtag);
        int bad_r, bad_m, fr, fm;
        bad_r = 0; bad_m = 0; fr = 0; fm = 0;
        for (int i = 0; i < 32; i++)
            if (brf[i] !== erf[i]) begin if (bad_r == 0) fr = i; bad_r++; end
        for (int i = 0; i < 256; i++)
            if (bmem[i] !== emem[i]) begin if (bad_m == 0) fm = i; bad_m++; end
        check(bad_r == 0, rtag, brf[fr], erf[fr]);
        check(bad_m == 0, mtag, 32'(bmem[fm]), 32'(emem[fm]));
    endtask

    // Issue a command and wait for done; returns whether done came in time.
    task automatic run_cmd(input bit st, input bit mu, input int r, input int a,
                           input int n, output bit got_done, output int done_cyc);
        @(negedge clk);
        word_hs = 0; byte_hs = 0;
        cmd_store = st; cmd_multi = mu; cmd_reg = 5'(r);
        cmd_addr = 32'(a); cmd_count = 8'(n); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got_done = 1'b0; done_cyc = 0;
        for (int k = 0; k < 2000; k++) begin
            if (done) begin got_done = 1'b1; done_cyc = cyc; break; end
            @(negedge clk);
        end
    endtask

    // Vector fields: store, multi, reg[4:0], addr[7:0], count[7:0], stall.
    localparam int NV = 11;
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 1'b0, 5'd3,  8'h10, 8'd7,  1'b0},
        {1'b0, 1'b0, 5'd5,  8'h21, 8'd9,  1'b1},
        {1'b0, 1'b0, 5'd30, 8'h40, 8'd14, 1'b1},
        {1'b1, 1'b0, 5'd2,  8'h80, 8'd6,  1'b1},
        {1'b1, 1'b0, 5'd31, 8'h90, 8'd11, 1'b0},
        {1'b0, 1'b1, 5'd27, 8'hA0, 8'd3,  1'b0},
        {1'b1, 1'b1, 5'd29, 8'hC0, 8'd0,  1'b1},
        {1'b0, 1'b0, 5'd7,  8'h05, 8'd3,  1'b1},
        {1'b0, 1'b0, 5'd10, 8'h60, 8'd8,  1'b0},
        {1'b1, 1'b0, 5'd12, 8'hE3, 8'd1,  1'b1},
        {1'b1, 1'b0, 5'd20, 8'hF0, 8'd10, 1'b1}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        bit got;
        int dc;
        int he;
        init_state(0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !mem_req && !rf_we, "R1 reset outputs",
              {28'h0, busy, done, mem_req, rf_we}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            e = VEC[v];
            stall_en = e[0];
            init_state(v);
            compute_ref(e[23], e[22], int'(e[21:17]), int'(e[16:9]), int'(e[8:1]));
            he = hold_err;
            run_cmd(e[23], e[22], int'(e[21:17]), int'(e[16:9]), int'(e[8:1]), got, dc);
            check(got, "R10 done seen", 32'(got), 32'h1);
            // R10: done right after the final handshake
            check(dc == last_hs + 1, "R10 done timing", 32'(dc), 32'(last_hs + 1));
            if (e[22])
                check(word_hs == exp_words && byte_hs == 0, "R7 multi word count",
                      32'(word_hs), 32'(exp_words));
            else begin
                check(word_hs == exp_words, "R2 word access count", 32'(word_hs), 32'(exp_words));
                check(byte_hs == exp_bytes, "R3 byte access count", 32'(byte_hs), 32'(exp_bytes));
            end
            // R4/R5/R6/R12 all visible through final register and memory state
            if (e[23]) compare_all("R12 store leaves registers", "R5 store memory image");
            else       compare_all("R4 load register image R6 R12", "R12 load leaves memory");
            check(hold_err == he, "R9 request held under stall", 32'(hold_err), 32'(he));
            @(negedge clk);
            check(!done && !busy, "R10 done one cycle", {30'h0, done, busy}, 32'h0);
        end

        // R8: zero count, string mode
        stall_en = 1'b0;
        init_state(20);
        compute_ref(1'b0, 1'b0, 4, 8'h30, 0);
        run_cmd(1'b0, 1'b0, 4, 8'h30, 0, got, dc);
        check(got && word_hs == 0 && byte_hs == 0, "R8 zero count no access",
              32'(word_hs + byte_hs), 32'h0);
        compare_all("R8 zero count registers", "R8 zero count memory");

        // R11: a command offered mid-transfer is ignored
        stall_en = 1'b1;
        init_state(21);
        compute_ref(1'b0, 1'b0, 4, 8'h30, 8);
        @(negedge clk);
        word_hs = 0; byte_hs = 0;
        cmd_store = 1'b0; cmd_multi = 1'b0; cmd_reg = 5'd4; cmd_addr = 32'h30;
        cmd_count = 8'd8; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        cmd_store = 1'b1; cmd_multi = 1'b1; cmd_reg = 5'd0; cmd_addr = 32'h00;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        got = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (done) begin got = 1'b1; break; end
            @(negedge clk);
        end
        check(got && word_hs == 2 && byte_hs == 0, "R11 busy command ignored",
              32'(word_hs), 32'h2);
        compare_all("R11 registers after ignored command", "R11 memory untouched");
        repeat (3) @(negedge clk);
        check(!busy && !mem_req, "R11 no second transfer", {30'h0, busy, mem_req}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule